// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block sits around an embedded core and decides where the core's terminals connect. In functional operation the core's input and output pins pass straight through between the core and the system logic. Under test, each core terminal goes through a wrapper cell. Each cell has a shift stage and an update stage. The cells on each wire of a narrow test access bus are chained together, so stimulus can be shifted in and response shifted out. A core with many terminals can therefore be reached through only a few test wires.

A two-bit mode word selects how the cells are steered. The word is loaded serially into a shift stage and only takes effect when an update strobe copies it into a hold stage. The four modes are: pass-through; testing the core itself; testing the wiring and logic around the core; and a one-flop bypass per access wire. The bypass lets several wrapped cores share one daisy-chained rail. The core is represented by a small combinational stand-in. In mode `k`, output `j` equals `core_in[j mod N_IN] XOR core_in[(j+1) mod N_IN]`.

Top module: `cwrap_top`

## Requirements
- R1: While `rst` is high and after it falls, the mode is normal, every cell's shift and update stage is 0, and `tst_out` is 0 on every wire.
- R2: In normal mode (code 2'b00) the core receives `sys_in` unchanged, and `sys_out[j]` equals `sys_in[j mod N_IN] ^ sys_in[(j+1) mod N_IN]`.
- R3: The mode word is shifted in LSB first on `ctl_si` while `ctl_shift` is high. It changes the wrapper's behaviour only on a cycle with `ctl_update` high. The codes are 00 normal, 01 core test, 10 interconnect test and 11 bypass.
- R4: In core test mode (01) the core's inputs are the update stages of the input cells, and `sys_out` is held at 0.
- R5: In core test mode a capture cycle loads the core's outputs into the output cells' shift stages and leaves the input cells unchanged.
- R6: In interconnect test mode (10) `sys_out` equals the output cells' update stages and the core's inputs are forced to 0. A capture cycle loads `sys_in` into the input cells' shift stages and leaves the output cells unchanged.
- R7: In bypass mode (11) `tst_out[w]` equals `tst_in[w]` of the previous cycle, `sys_out` is 0, and no wrapper cell shifts.
- R8: Terminals are dealt round-robin to the wires. Chain `w` holds input cells `i ≡ w (mod W)` in ascending order, followed by output cells `j ≡ w (mod W)` in ascending order. Each shift cycle moves data one position, `tst_in[w]` enters the first cell, and `tst_out[w]` shows the last cell.
- R9: A cell's update stage, and with it the value the cell drives, changes only on a cycle with `wc_update` high.
- R10: When `wc_capture` and `wc_shift` are both high, the cells that capture do so and no chain shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_in | input | N_IN | System logic driving the core's inputs |
| sys_out | output | N_OUT | Core's outputs as seen by system logic |
| ctl_si | input | 1 | Serial mode bit |
| ctl_shift | input | 1 | Shift the mode shift stage |
| ctl_update | input | 1 | Copy the mode shift stage into the hold stage |
| wc_shift | input | 1 | Shift all wrapper cell chains |
| wc_capture | input | 1 | Capture into wrapper cell shift stages |
| wc_update | input | 1 | Copy cell shift stages into update stages |
| tst_in | input | W | Test access bus, one chain per wire |
| tst_out | output | W | Test access bus return, registered |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any control activity. They also assume that the capture, shift and bypass checks only look back one cycle, to a cycle when reset was already low. The bench drives every input at the falling edge and releases reset before it pulses any control line. It changes mode only through the serial path, with the cell controls held low, so a mode switch never coincides with a cell shift or capture. Every scan is a full-length pass of the longest chain, so shorter chains are padded with leading zeros that fall off their tail.

// File: rtl/cwrap_pkg.sv
`timescale 1ns/1ps
package cwrap_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_CORE   = 2'b01,
    WM_XCONN  = 2'b10,
    WM_BYPASS = 2'b11
  } wmode_e;
endpackage

// File: rtl/cwrap_mode_reg.sv
`timescale 1ns/1ps
module cwrap_mode_reg
  import cwrap_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   si,
  input  logic   shift_en,
  input  logic   upd_en,
  output wmode_e mode
);
  logic [1:0] stage;

  // Bits enter at the top and move down, so the first bit lands in bit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= 2'b00;
      mode  <= WM_NORMAL;
    end else begin
      if (shift_en) stage <= {si, stage[1]};
      if (upd_en)   mode  <= wmode_e'(stage);
    end
  end

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> mode == $past(mode));
endmodule

// File: rtl/cwrap_bcell.sv
`timescale 1ns/1ps
module cwrap_bcell (
  input  logic clk,
  input  logic rst,
  input  logic func_in,
  input  logic scan_in,
  input  logic shift_en,
  input  logic cap_en,
  input  logic upd_en,
  output logic scan_q,
  output logic upd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      if (cap_en)        scan_q <= func_in;
      else if (shift_en) scan_q <= scan_in;
      if (upd_en)        upd_q  <= scan_q;
    end
  end

  assert_upd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(upd_q));
endmodule

// File: rtl/cwrap_core_model.sv
`timescale 1ns/1ps
module cwrap_core_model #(
  parameter int NI = 6,
  parameter int NO = 5
) (
  input  logic [NI-1:0] din,
  output logic [NO-1:0] dout
);
  for (genvar j = 0; j < NO; j++) begin : g_o
    localparam int A = j % NI;
    localparam int B = (j + 1) % NI;
    assign dout[j] = din[A] ^ din[B];
  end
endmodule

// File: rtl/cwrap_bypass.sv
`timescale 1ns/1ps
module cwrap_bypass #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= din;
  end
endmodule

// File: rtl/cwrap_top.sv
`timescale 1ns/1ps
module cwrap_top
  import cwrap_pkg::*;
#(
  parameter int N_IN  = 6,  // must be >= W
  parameter int N_OUT = 5,  // must be >= W
  parameter int W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  sys_in,
  output logic [N_OUT-1:0] sys_out,
  input  logic             ctl_si,
  input  logic             ctl_shift,
  input  logic             ctl_update,
  input  logic             wc_shift,
  input  logic             wc_capture,
  input  logic             wc_update,
  input  logic [W-1:0]     tst_in,
  output logic [W-1:0]     tst_out
);
  wmode_e           mode;
  logic [N_IN-1:0]  in_sh, in_up, in_si, core_in;
  logic [N_OUT-1:0] out_sh, out_up, out_si, core_out;
  logic [W-1:0]     byp_q, chain_tail;
  logic             cell_shift, in_cap, out_cap;

  cwrap_mode_reg u_mode (
    .clk(clk), .rst(rst), .si(ctl_si), .shift_en(ctl_shift),
    .upd_en(ctl_update), .mode(mode)
  );

  // Capture wins over shift; bypass freezes every chain.
  assign cell_shift = wc_shift & ~wc_capture & (mode != WM_BYPASS);
  assign in_cap     = wc_capture & (mode == WM_XCONN);
  assign out_cap    = wc_capture & (mode == WM_CORE);

  // Input side: chain w starts at input cell w.
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    if (i >= W) begin : g_link
      assign in_si[i] = in_sh[i-W];
    end else begin : g_head
      assign in_si[i] = tst_in[i];
    end
    cwrap_bcell u_cell (
      .clk(clk), .rst(rst), .func_in(sys_in[i]), .scan_in(in_si[i]),
      .shift_en(cell_shift), .cap_en(in_cap), .upd_en(wc_update),
      .scan_q(in_sh[i]), .upd_q(in_up[i])
    );
  end

  // Output side: first output cell on a wire follows that wire's last input cell.
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    if (j >= W) begin : g_link
      assign out_si[j] = out_sh[j-W];
    end else begin : g_join
      localparam int LAST_IN = j + W * ((N_IN - 1 - j) / W);
      assign out_si[j] = in_sh[LAST_IN];
    end
    cwrap_bcell u_cell (
      .clk(clk), .rst(rst), .func_in(core_out[j]), .scan_in(out_si[j]),
      .shift_en(cell_shift), .cap_en(out_cap), .upd_en(wc_update),
      .scan_q(out_sh[j]), .upd_q(out_up[j])
    );
  end

  for (genvar w = 0; w < W; w++) begin : g_tail
    localparam int LAST_OUT = w + W * ((N_OUT - 1 - w) / W);
    assign chain_tail[w] = out_sh[LAST_OUT];

    assert_chain_head_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(cell_shift) && $past(!rst)) |-> in_sh[w] == $past(tst_in[w]));
  end

  cwrap_bypass #(.W(W)) u_byp (.clk(clk), .rst(rst), .din(tst_in), .dout(byp_q));

  cwrap_core_model #(.NI(N_IN), .NO(N_OUT)) u_core (.din(core_in), .dout(core_out));

  always_comb begin
    unique case (mode)
      WM_NORMAL: core_in = sys_in;
      WM_CORE:   core_in = in_up;
      default:   core_in = '0;
    endcase
  end

  always_comb begin
    unique case (mode)
      WM_NORMAL: sys_out = core_out;
      WM_XCONN:  sys_out = out_up;
      default:   sys_out = '0;
    endcase
  end

  assign tst_out = (mode == WM_BYPASS) ? byp_q : chain_tail;

  assert_core_capture_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(out_cap) && $past(!rst)) |-> (out_sh == $past(core_out) && in_sh == $past(in_sh)));

  assert_xconn_capture_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(in_cap) && $past(!rst)) |-> (in_sh == $past(sys_in) && out_sh == $past(out_sh)));

  assert_bypass_delay_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_BYPASS) |-> tst_out == $past(tst_in));
endmodule

// File: tb/sim_cwrap_top.sv
`timescale 1ns/1ps
module sim_cwrap_top;
  localparam int NI = 6, NO = 5, NW = 2, L = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [NI-1:0] sys_in = '0;
  logic [NO-1:0] sys_out;
  logic ctl_si = 0, ctl_shift = 0, ctl_update = 0;
  logic wc_shift = 0, wc_capture = 0, wc_update = 0;
  logic [NW-1:0] tst_in = '0, tst_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cwrap_top #(.N_IN(NI), .N_OUT(NO), .W(NW)) u0 (
    .clk(clk), .rst(rst), .sys_in(sys_in), .sys_out(sys_out),
    .ctl_si(ctl_si), .ctl_shift(ctl_shift), .ctl_update(ctl_update),
    .wc_shift(wc_shift), .wc_capture(wc_capture), .wc_update(wc_update),
    .tst_in(tst_in), .tst_out(tst_out)
  );

  function automatic logic [NO-1:0] fcore(logic [NI-1:0] a);
    logic [NO-1:0] r;
    for (int j = 0; j < NO; j++) r[j] = a[j % NI] ^ a[(j + 1) % NI];
    return r;
  endfunction

  function automatic int nin_w(int w);  return (NI - 1 - w) / NW + 1; endfunction
  function automatic int len_w(int w);  return nin_w(w) + (NO - 1 - w) / NW + 1; endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(logic [1:0] m);
    ctl_shift = 1; ctl_si = m[0]; tick();
    ctl_si = m[1]; tick();
    ctl_shift = 0; ctl_update = 1; tick();
    ctl_update = 0; ctl_si = 0;
  endtask

  task automatic pulse_update();
    wc_update = 1; tick(); wc_update = 0;
  endtask

  task automatic pulse_capture();
    wc_capture = 1; tick(); wc_capture = 0;
  endtask

  // Full-length scan: loads ain/bout into chain positions, returns prior contents.
  task automatic scan(input logic [NI-1:0] ain, input logic [NO-1:0] bout,
                      output logic [NI-1:0] ain_got, output logic [NO-1:0] bout_got);
    ain_got = '0; bout_got = '0;
    for (int t = 0; t < L; t++) begin
      for (int w = 0; w < NW; w++) begin
        int lw, p, q;
        lw = len_w(w);
        if (t < lw) begin
          p = lw - 1 - t;
          if (p < nin_w(w)) ain_got[w + NW * p] = tst_out[w];
          else bout_got[w + NW * (p - nin_w(w))] = tst_out[w];
        end
        q = L - 1 - t;
        if (q < lw) begin
          if (q < nin_w(w)) tst_in[w] = ain[w + NW * q];
          else tst_in[w] = bout[w + NW * (q - nin_w(w))];
        end else tst_in[w] = 1'b0;
      end
      wc_shift = 1; tick();
    end
    wc_shift = 0; tst_in = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NI-1:0] ag; logic [NO-1:0] bg;
    logic [NI-1:0] a;  logic [NO-1:0] b, p2;
    logic [NW-1:0] prev;
    @(negedge clk); sys_in = 6'h2d; tick(); tick();
    // R1: state during reset
    check(tst_out == 0, "R1 tst_out in reset", 8'(tst_out), 0);
    check(sys_out == fcore(6'h2d), "R1 normal in reset", 8'(sys_out), 8'(fcore(6'h2d)));
    rst = 0; tick();
    check(tst_out == 0, "R1 tst_out after reset", 8'(tst_out), 0);
    scan('0, '0, ag, bg);
    check(ag == 0 && bg == 0, "R1 cells zero after reset", 8'({bg, ag[2:0]}), 0);

    // R2: exhaustive normal-mode sweep
    for (int k = 0; k < 64; k++) begin
      sys_in = 6'(k); #1;
      check(sys_out == fcore(6'(k)), "R2 normal pass-through", 8'(sys_out), 8'(fcore(6'(k))));
    end
    sys_in = 6'h15;

    // R3: shifting without update keeps normal mode
    ctl_shift = 1; ctl_si = 1; tick(); ctl_si = 0; tick(); ctl_shift = 0; #1;
    check(sys_out == fcore(6'h15), "R3 no update no change", 8'(sys_out), 8'(fcore(6'h15)));
    ctl_update = 1; tick(); ctl_update = 0; #1;
    check(sys_out == 0, "R3/R4 update applies core test", 8'(sys_out), 0);

    // R4/R5: exhaustive core test over input cell values
    for (int k = 0; k < 64; k++) begin
      a = 6'(k);
      scan(a, 5'h0, ag, bg);
      pulse_update();
      check(sys_out == 0, "R4 output isolated", 8'(sys_out), 0);
      pulse_capture();
      scan('0, '0, ag, bg);
      check(bg == fcore(a), "R4/R5 core response", 8'(bg), 8'(fcore(a)));
      check(ag == a, "R5 input cells untouched by capture", 8'(ag), 8'(a));
    end

    // R10: capture with shift high does not shift
    a = 6'h39;
    scan(a, 5'h0, ag, bg); pulse_update();
    wc_capture = 1; wc_shift = 1; tick(); wc_capture = 0; wc_shift = 0;
    scan('0, '0, ag, bg);
    check(ag == a, "R10 no shift during capture", 8'(ag), 8'(a));
    check(bg == fcore(a), "R10 capture still taken", 8'(bg), 8'(fcore(a)));

    // R6/R9: interconnect test, exhaustive over output cell values
    set_mode(2'b10);
    for (int k = 0; k < 32; k++) begin
      b = 5'(k);
      scan(6'h0, b, ag, bg);
      pulse_update(); #1;
      check(sys_out == b, "R6 drive from output cells", 8'(sys_out), 8'(b));
      p2 = ~b;
      scan(6'h0, p2, ag, bg); #1;
      check(sys_out == b, "R9 shift without update holds", 8'(sys_out), 8'(b));
      sys_in = 6'((k * 7 + 3) & 63);
      pulse_capture();
      scan('0, '0, ag, bg);
      check(ag == sys_in, "R6 capture from system", 8'(ag), 8'(sys_in));
      check(bg == p2, "R6 output cells untouched", 8'(bg), 8'(p2));
    end

    // R7/R8: bypass; cells hold a known pattern through it
    a = 6'h2b; b = 5'h16;
    scan(a, b, ag, bg);
    set_mode(2'b11);
    prev = tst_in;
    for (int t = 0; t < 16; t++) begin
      logic [NW-1:0] nv;
      nv = NW'((t * 3 + 1) & 3);
      check(tst_out == prev, "R7 one-cycle bypass", 8'(tst_out), 8'(prev));
      tst_in = nv; prev = nv; wc_shift = 1; #1;
      check(sys_out == 0, "R7 output isolated", 8'(sys_out), 0);
      tick();
    end
    wc_shift = 0; tst_in = '0; tick();
    set_mode(2'b10);
    scan('0, '0, ag, bg);
    check(ag == a, "R7/R8 input cells held in bypass", 8'(ag), 8'(a));
    check(bg == b, "R7/R8 output cells held in bypass", 8'(bg), 8'(b));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule